// File: doc/BRIEF.md
# Color channel multiplexer sequencer

This block drives the channel select of the analog multiplexer that sits in front of the single converter of a three-input pixel digitizer. It also labels every converter sample with the channel it came from. Both clocks of the analog front end arrive as level inputs and are sampled on the block clock. These are the converter clock and the data-sample clock. Their edges are found by edge detection.

A rising edge of the data-sample clock restarts the channel sequence. The next rising edge of the converter clock selects the first channel of the sequence. Each later converter rising edge steps to the next channel. After the last channel the select stays where it is until the next restart.

The sequence depends on the mode inputs:
- In three-channel mode, all three colors are scanned in one of two orders.
- In two-channel mode, a pair chosen by an enable mask is scanned, in the order set by the order bit.
- In one-channel mode, the select is held on a single color.

Each converter falling edge captures the current select. That channel code is carried through a delay line matching the converter pipeline, so the tag leaves the block together with the data word it describes.

Top module: `chan_mux_seq`

## Requirements
- R1: After reset the select is red (code 0, one-hot 3'b001), the tag valid output is low, and the sequence is armed so that the first converter rising edge selects the first channel.
- R2: The select (channel code 0 = red, 1 = green, 2 = blue; one-hot bit n set for code n) changes only in the cycle after a detected converter-clock rising edge. The one-hot output always has exactly one bit set, at the position of the code.
- R3: A data-sample clock rising edge re-arms the sequence without moving the select. The next converter rising edge selects position 0 of the sequence. A converter rising edge in the same cycle as the strobe counts as that first edge.
- R4: Each later converter rising edge advances one position. On the last position of the sequence the select holds until the sequence is re-armed.
- R5: With three_ch_i = 1, the sequence is red, green, blue when order_i = 1, and blue, green, red when order_i = 0.
- R6: With three_ch_i = 0 and exactly two bits of ch_en_i set (bit 2 = red, bit 1 = green, bit 0 = blue), the two enabled channels are scanned. With order_i = 1 the one with the lower code comes first; with order_i = 0 the one with the higher code comes first.
- R7: With three_ch_i = 0 and exactly one bit of ch_en_i set, the select stays on that channel for every converter edge.
- R8: With three_ch_i = 0 and zero or three bits of ch_en_i set, the block acts as one-channel mode on red.
- R9: Each converter falling edge captures the current select code. After TAG_LAT further falling edges, counting the capturing edge as the first, it appears on tag_ch_o with tag_valid_o high. tag_valid_o stays low until TAG_LAT captures have happened since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_clk_i | input | 1 | Converter clock level, sampled on clk_i |
| dsc_clk_i | input | 1 | Data-sample clock level, sampled on clk_i |
| three_ch_i | input | 1 | Three-channel mode enable |
| order_i | input | 1 | Channel order: 1 = red first, 0 = blue first |
| ch_en_i | input | 3 | Channel enable mask: bit 2 red, bit 1 green, bit 0 blue |
| sel_code_o | output | 2 | Selected channel code |
| sel_onehot_o | output | 3 | Selected channel, one-hot |
| tag_valid_o | output | 1 | Tag valid, aligned with converter output word |
| tag_ch_o | output | 2 | Channel code of the aligned output word |

## Verification
The data-sample strobe and a converter rising edge can be detected in the same block-clock cycle. In that case the restart and the first-channel selection must both take effect from that one edge. The bench provokes this by raising both clock levels on the same drive edge, in random and directed sequences, with every mode setting. It then expects position 0 selected after that cycle and position 1 after the following converter edge. A plain strobe, with no converter edge beside it, is checked to leave the select unchanged until the next converter edge.

// File: rtl/chan_mux_seq_pkg.sv
package chan_mux_seq_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_W   = 2;
  localparam int POS_W  = 2;

  localparam logic [CH_W-1:0] CH_RED   = 2'd0;
  localparam logic [CH_W-1:0] CH_GREEN = 2'd1;
  localparam logic [CH_W-1:0] CH_BLUE  = 2'd2;

  typedef logic [CH_W-1:0] chan_t;
  typedef logic [NUM_CH-1:0][CH_W-1:0] chan_list_t;

  typedef struct packed {
    logic  valid;
    chan_t ch;
  } tag_t;
endpackage

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/seq_order.sv
module seq_order
  import chan_mux_seq_pkg::*;
(
  input  logic             three_ch_i,
  input  logic             order_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [POS_W-1:0] len_o,
  output chan_list_t       list_o
);
  logic [1:0] n_en;
  chan_t      lo_ch, hi_ch, solo_ch;

  assign n_en = 2'($countones(en_i));

  // enabled pair, lower code first
  always_comb begin
    if (en_i[2]) begin
      lo_ch = CH_RED;
      hi_ch = en_i[1] ? CH_GREEN : CH_BLUE;
    end else begin
      lo_ch = CH_GREEN;
      hi_ch = CH_BLUE;
    end
  end

  // zero or three set bits fall back to red
  always_comb begin
    if (n_en == 2'd1) solo_ch = en_i[2] ? CH_RED : (en_i[1] ? CH_GREEN : CH_BLUE);
    else              solo_ch = CH_RED;
  end

  always_comb begin
    if (three_ch_i) begin
      len_o = POS_W'(3);
      if (order_i) list_o = {CH_BLUE, CH_GREEN, CH_RED};
      else         list_o = {CH_RED, CH_GREEN, CH_BLUE};
    end else if (n_en == 2'd2) begin
      len_o = POS_W'(2);
      list_o[0] = order_i ? lo_ch : hi_ch;
      list_o[1] = order_i ? hi_ch : lo_ch;
      list_o[2] = list_o[1];
    end else begin
      len_o = POS_W'(1);
      list_o = {solo_ch, solo_ch, solo_ch};
    end
  end
endmodule

// File: rtl/seq_pos_ctr.sv
module seq_pos_ctr
  import chan_mux_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adc_rise_i,
  input  logic             dsc_rise_i,
  input  logic [POS_W-1:0] len_i,
  output logic [POS_W-1:0] pos_d_o,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q;
  logic             armed_q;
  logic [POS_W:0]   pos_inc;

  assign pos_inc = {1'b0, pos_q} + 1'b1;

  always_comb begin
    pos_d_o = pos_q;
    if (adc_rise_i) begin
      if (armed_q || dsc_rise_i)       pos_d_o = '0;
      else if (pos_inc < {1'b0, len_i}) pos_d_o = pos_inc[POS_W-1:0];
      else                              pos_d_o = len_i - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      pos_q <= pos_d_o;
      if (adc_rise_i)      armed_q <= 1'b0;
      else if (dsc_rise_i) armed_q <= 1'b1;
    end
  end

  assign pos_o = pos_q;

  a_r3_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsc_rise_i && !adc_rise_i) |=> armed_q);
  a_r3_first_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rise_i && (armed_q || dsc_rise_i)) |=> (pos_q == '0) && !armed_q);
  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rise_i && !armed_q && !dsc_rise_i && (pos_inc < {1'b0, len_i}))
      |=> pos_q == $past(pos_q) + 1'b1);
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rise_i |=> $stable(pos_q));
endmodule

// File: rtl/seq_tag_pipe.sv
module seq_tag_pipe
  import chan_mux_seq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  shift_i,
  input  chan_t ch_i,
  output tag_t  tag_o
);
  tag_t stage_q [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stage_q[s] <= '0;
        else if (shift_i) begin
          if (s == 0) stage_q[s] <= '{valid: 1'b1, ch: ch_i};
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign tag_o = stage_q[DEPTH-1];

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(tag_o));
  a_r9_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o.valid |=> tag_o.valid);
endmodule

// File: rtl/chan_mux_seq.sv
module chan_mux_seq
  import chan_mux_seq_pkg::*;
#(
  parameter int TAG_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adc_clk_i,
  input  logic             dsc_clk_i,
  input  logic             three_ch_i,
  input  logic             order_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  output logic [CH_W-1:0]   sel_code_o,
  output logic [NUM_CH-1:0] sel_onehot_o,
  output logic             tag_valid_o,
  output logic [CH_W-1:0]   tag_ch_o
);
  localparam int N_CLK = 2;

  logic [N_CLK-1:0] rise, fall;
  logic             adc_rise, adc_fall, dsc_rise;
  logic [POS_W-1:0] seq_len, pos_d, pos_q;
  chan_list_t       seq_list;
  chan_t            sel_q;
  tag_t             tag;

  seq_edge_det #(.W(N_CLK)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({dsc_clk_i, adc_clk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign adc_rise = rise[0];
  assign adc_fall = fall[0];
  assign dsc_rise = rise[1];

  seq_order u_order (
    .three_ch_i (three_ch_i),
    .order_i    (order_i),
    .en_i       (ch_en_i),
    .len_o      (seq_len),
    .list_o     (seq_list)
  );

  seq_pos_ctr u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adc_rise_i (adc_rise),
    .dsc_rise_i (dsc_rise),
    .len_i      (seq_len),
    .pos_d_o    (pos_d),
    .pos_o      (pos_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= CH_RED;
    else if (adc_rise) sel_q <= seq_list[pos_d];
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_onehot
      assign sel_onehot_o[c] = (sel_q == CH_W'(c));
    end
  endgenerate

  assign sel_code_o = sel_q;

  seq_tag_pipe #(.DEPTH(TAG_LAT)) u_tag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (adc_fall),
    .ch_i    (sel_q),
    .tag_o   (tag)
  );

  assign tag_valid_o = tag.valid;
  assign tag_ch_o    = tag.ch;

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sel_onehot_o));
  a_r2_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rise |=> $stable(sel_code_o));
  a_r7_single_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rise && seq_len == POS_W'(1)) |=> sel_code_o == $past(seq_list[0]));
  a_r5_three_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rise && three_ch_i && pos_d == '0)
      |=> sel_code_o == ($past(order_i) ? CH_RED : CH_BLUE));
endmodule

// File: tb/chan_mux_seq_bench.sv
module chan_mux_seq_bench;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       adc_clk = 1'b0, dsc_clk = 1'b0;
  logic       three_ch = 1'b1, order = 1'b1;
  logic [2:0] ch_en = 3'b100;
  logic [1:0] sel_code, tag_ch;
  logic [2:0] sel_onehot;
  logic       tag_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int m_pos = 0;
  bit m_armed = 1;
  int m_sel = 0;
  bit p_val [LAT];
  int p_ch  [LAT];

  always #10 clk = ~clk;

  chan_mux_seq #(.TAG_LAT(LAT)) u_chan_mux_seq (
    .clk_i(clk), .rst_ni(rst_ni), .adc_clk_i(adc_clk), .dsc_clk_i(dsc_clk),
    .three_ch_i(three_ch), .order_i(order), .ch_en_i(ch_en),
    .sel_code_o(sel_code), .sel_onehot_o(sel_onehot),
    .tag_valid_o(tag_valid), .tag_ch_o(tag_ch)
  );

  function automatic int seq_len(bit t, bit [2:0] en);
    if (t) return 3;
    if ($countones(en) == 2) return 2;
    return 1;
  endfunction

  // channel codes: red 0, green 1, blue 2; en bit2 red, bit1 green, bit0 blue
  function automatic int exp_chan(int pos, bit t, bit o, bit [2:0] en);
    int a, b;
    if (t) return o ? pos : 2 - pos;
    if ($countones(en) == 2) begin
      a = en[2] ? 0 : 1;
      b = en[0] ? 2 : 1;
      if (pos == 0) return o ? a : b;
      return o ? b : a;
    end
    if ($countones(en) == 1) return en[2] ? 0 : (en[1] ? 1 : 2);
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_sel(string req);
    check(req, sel_code, m_sel);
    check({req, " onehot"}, sel_onehot, 1 << m_sel);
  endtask

  task automatic model_rise();
    int len = seq_len(three_ch, ch_en);
    if (m_armed) m_pos = 0;
    else if (m_pos + 1 < len) m_pos++;
    else m_pos = len - 1;
    m_armed = 0;
    m_sel = exp_chan(m_pos, three_ch, order, ch_en);
  endtask

  task automatic model_fall();
    for (int i = LAT - 1; i > 0; i--) begin
      p_val[i] = p_val[i-1];
      p_ch[i]  = p_ch[i-1];
    end
    p_val[0] = 1;
    p_ch[0]  = m_sel;
  endtask

  task automatic check_tag(string req);
    check({req, " valid"}, tag_valid, p_val[LAT-1]);
    if (p_val[LAT-1]) check({req, " ch"}, tag_ch, p_ch[LAT-1]);
  endtask

  task automatic adc_cycle(string req);
    @(negedge clk) adc_clk = 1'b1;
    @(negedge clk);
    model_rise();
    check_sel(req);
    adc_clk = 1'b0;
    @(negedge clk);
    model_fall();
    check_tag("R9 tag");
  endtask

  task automatic strobe(bit coinc);
    @(negedge clk) begin dsc_clk = 1'b1; adc_clk = coinc; end
    @(negedge clk);
    m_armed = 1;
    if (coinc) model_rise();
    check_sel(coinc ? "R3 coincident strobe" : "R3 strobe keeps select");
    dsc_clk = 1'b0;
    adc_clk = 1'b0;
    @(negedge clk);
    if (coinc) begin
      model_fall();
      check_tag("R9 tag after coincident");
    end
  endtask

  task automatic set_cfg(bit t, bit o, bit [2:0] en);
    @(negedge clk) begin three_ch = t; order = o; ch_en = en; end
  endtask

  task automatic run_seq(bit t, bit o, bit [2:0] en, string req);
    set_cfg(t, o, en);
    strobe(0);
    for (int k = 0; k < 4; k++) adc_cycle(req);
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) begin p_val[i] = 0; p_ch[i] = 0; end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset select", sel_code, 0);
    check("R1 reset onehot", sel_onehot, 3'b001);
    check("R1 reset tag valid", tag_valid, 0);
    // R2: idle cycles leave select alone
    repeat (5) @(negedge clk);
    check("R2 idle hold", sel_code, 0);
    // R1: first edge after reset selects first channel (blue, order 0)
    set_cfg(1, 0, 3'b100);
    adc_cycle("R1 first edge after reset");
    check("R9 valid low before fill", tag_valid, 0);
    // R5 three-channel, both orders, includes R4 hold on last
    run_seq(1, 1, 3'b000, "R5 RGB / R4 hold");
    run_seq(1, 0, 3'b111, "R5 BGR / R4 hold");
    // R6 all pairs, both orders
    for (int o = 0; o < 2; o++) begin
      run_seq(0, o[0], 3'b110, "R6 pair RG");
      run_seq(0, o[0], 3'b101, "R6 pair RB");
      run_seq(0, o[0], 3'b011, "R6 pair GB");
    end
    // R7 single channels
    run_seq(0, 1, 3'b010, "R7 single green");
    run_seq(0, 0, 3'b001, "R7 single blue");
    run_seq(0, 1, 3'b100, "R7 single red");
    // R8 fallback
    run_seq(0, 0, 3'b000, "R8 none enabled");
    run_seq(0, 0, 3'b111, "R8 all enabled");
    // R3 coincident strobe in three-channel mode
    set_cfg(1, 1, 3'b000);
    adc_cycle("R4 advance");
    strobe(1);
    adc_cycle("R3 second after coincident");
    // R3 strobe mid-sequence restarts
    strobe(0);
    adc_cycle("R3 restart first");
    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom % 10;
      if (r < 2) begin
        set_cfg($urandom % 2, $urandom % 2, 3'($urandom % 8));
        strobe(0);
      end else if (r == 2) begin
        strobe(1);
      end else begin
        adc_cycle("R4 random advance");
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule